// File: doc/BRIEF.md
# Strided Transfer Address Generator

This block produces the word addresses for a block transfer that moves items between local memory, where they are spaced out, and a message buffer, where they are packed. A transfer is set up by a start pulse. The pulse carries a memory base address, an item spacing, a group gap, a per-group item count and a group count. The engine then offers one beat per address pair on a valid/ready stream. Each beat carries the memory-side word address and the buffer-side slot index.

The memory side follows a two-level pattern. Items inside a group sit a fixed spacing apart. The first item of the next group sits a separate gap after the last item of the previous group. Item (i, g) therefore lands at base + i*stride + g*(stride*(inner-1) + skip). For example, with stride 3, three items per group and gap 4, the groups start 10 words apart.

A direction input chooses between two modes. In gather mode, spaced-out memory is read into consecutive buffer slots. In scatter mode, consecutive buffer slots are written out to spaced-out memory. The same address sequence serves both modes; only the memory-write flag on the beats differs.

The stream obeys back-pressure. While `beat_valid` is high and `beat_ready` is low, the beat is held unchanged. A beat is consumed only in a cycle where both are high. The engine never withdraws a beat it has offered.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset the engine is idle: `busy`, `beat_valid` and `done` are all low.
- R2: A start pulse seen while idle latches all configuration inputs. If both counts are non-zero, the first beat appears in the next cycle with `mem_addr` equal to the base and `buf_addr` equal to 0.
- R3: Within a group, each accepted beat advances `mem_addr` by the latched stride.
- R4: After the last item of a group is accepted, the next group's first `mem_addr` equals that last item's address plus the latched gap. This makes the group pitch stride*(inner-1) + gap.
- R5: `buf_addr` starts at 0 and rises by exactly one for each accepted beat.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `mem_addr`, `buf_addr` and `beat_last` hold their values into the next cycle.
- R7: A transfer yields exactly inner*groups beats. Only the final beat has `beat_last` high. `done` is high for exactly one cycle, starting the cycle after the final beat is accepted, and `beat_valid` is low while `done` is high.
- R8: If either count is zero at start, no beat is offered. `done` pulses in the cycle after the start.
- R9: A start pulse while `busy` is high (including the `done` cycle) is ignored. The running sequence is unchanged, and no further transfer follows.
- R10: `mem_write` is 1 for scatter (`dir_scatter`=1) and 0 for gather. It is latched at start and holds for the whole transfer.
- R11: Memory address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; latches configuration when idle |
| dir_scatter | input | 1 | 1 = scatter (buffer to memory), 0 = gather |
| cfg_base | input | AW | Memory address of the first item |
| cfg_stride | input | AW | Word spacing between items within a group |
| cfg_skip | input | AW | Word gap from a group's last item to the next group's first |
| cfg_inner | input | CW | Items per group |
| cfg_groups | input | CW | Number of groups |
| busy | output | 1 | High from an accepted start until the end of the done cycle |
| done | output | 1 | One-cycle completion pulse |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Consumer accepts the beat |
| mem_addr | output | AW | Memory word address of the beat |
| buf_addr | output | 2*CW | Buffer slot index of the beat |
| mem_write | output | 1 | 1 when the memory side is written (scatter) |
| beat_last | output | 1 | Marks the final beat of the transfer |

## Verification
Two functions can meet in one cycle: a new start request and the completion path. The completion path is either the acceptance of the final beat or the `done` pulse itself. The bench provokes this by raising `start`, with a different configuration, in exactly the cycle the last beat handshakes, and again during `done`. It judges the outcome at the ports: `done` lasts one cycle, and `beat_valid` and `busy` then stay low for several cycles. Start requests injected mid-transfer under back-pressure are judged the same way, by comparing every accepted beat against addresses computed from the pattern formula.

// File: rtl/strided_pkg.sv
package strided_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_FIN  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/strided_ctrl.sv
module strided_ctrl
  import strided_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_len,
  input  logic fire,
  input  logic final_beat,
  output logic load,
  output logic busy,
  output logic done,
  output logic valid
);
  eng_state_t state, state_nx;

  assign load  = (state == ENG_IDLE) && start;
  assign valid = (state == ENG_RUN);
  assign done  = (state == ENG_FIN);
  assign busy  = (state != ENG_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ENG_IDLE: if (start) state_nx = zero_len ? ENG_FIN : ENG_RUN;
      ENG_RUN:  if (fire && final_beat) state_nx = ENG_FIN;
      ENG_FIN:  state_nx = ENG_IDLE;
      default:  state_nx = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ENG_IDLE;
    else        state <= state_nx;
  end

  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && start && !fire |=> valid && !done);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && zero_len |=> done && !valid);
endmodule

// File: rtl/strided_counters.sv
module strided_counters #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fire,
  input  logic [CW-1:0] cfg_inner,
  input  logic [CW-1:0] cfg_groups,
  output logic          group_end,
  output logic          final_beat
);
  logic [CW-1:0] inner_lim, grp_lim;
  logic [CW-1:0] item_idx, grp_idx;

  assign group_end  = (item_idx == inner_lim - CW'(1));
  assign final_beat = group_end && (grp_idx == grp_lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_lim <= '0;
      grp_lim   <= '0;
      item_idx  <= '0;
      grp_idx   <= '0;
    end else if (load) begin
      inner_lim <= cfg_inner;
      grp_lim   <= cfg_groups;
      item_idx  <= '0;
      grp_idx   <= '0;
    end else if (fire && !final_beat) begin
      if (group_end) begin
        item_idx <= '0;
        grp_idx  <= grp_idx + CW'(1);
      end else begin
        item_idx <= item_idx + CW'(1);
      end
    end
  end

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (item_idx < inner_lim) && (grp_idx < grp_lim));
endmodule

// File: rtl/strided_addr_path.sv
module strided_addr_path #(
  parameter int AW = 16,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fire,
  input  logic          valid,
  input  logic          group_end,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_stride,
  input  logic [AW-1:0] cfg_skip,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] buf_addr
);
  logic [AW-1:0] stride_q, skip_q;
  logic [AW-1:0] step;

  assign step = group_end ? skip_q : stride_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      buf_addr <= '0;
      stride_q <= '0;
      skip_q   <= '0;
    end else if (load) begin
      mem_addr <= cfg_base;
      buf_addr <= '0;
      stride_q <= cfg_stride;
      skip_q   <= cfg_skip;
    end else if (fire) begin
      mem_addr <= mem_addr + step;
      buf_addr <= buf_addr + BW'(1);
    end
  end

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !fire |=> $stable(mem_addr) && $stable(buf_addr));

  // R5
  buf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> buf_addr == $past(buf_addr) + BW'(1));
endmodule

// File: rtl/strided_addr_gen.sv
module strided_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 8,
  localparam int BW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_scatter,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_stride,
  input  logic [AW-1:0] cfg_skip,
  input  logic [CW-1:0] cfg_inner,
  input  logic [CW-1:0] cfg_groups,
  output logic          busy,
  output logic          done,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] buf_addr,
  output logic          mem_write,
  output logic          beat_last
);
  logic load, fire, zero_len, group_end, final_beat;

  assign zero_len  = (cfg_inner == '0) || (cfg_groups == '0);
  assign fire      = beat_valid && beat_ready;
  assign beat_last = beat_valid && final_beat;

  strided_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .zero_len   (zero_len),
    .fire       (fire),
    .final_beat (final_beat),
    .load       (load),
    .busy       (busy),
    .done       (done),
    .valid      (beat_valid)
  );

  strided_counters #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .fire       (fire),
    .cfg_inner  (cfg_inner),
    .cfg_groups (cfg_groups),
    .group_end  (group_end),
    .final_beat (final_beat)
  );

  strided_addr_path #(.AW(AW), .BW(BW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .fire       (fire),
    .valid      (beat_valid),
    .group_end  (group_end),
    .cfg_base   (cfg_base),
    .cfg_stride (cfg_stride),
    .cfg_skip   (cfg_skip),
    .mem_addr   (mem_addr),
    .buf_addr   (buf_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mem_write <= 1'b0;
    else if (load) mem_write <= dir_scatter;
  end

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> (!beat_valid || $stable(mem_write)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid && busy);

  // R6
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_last));
endmodule

// File: tb/strided_addr_gen_bench.sv
module strided_addr_gen_bench;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int BW = 2 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_scatter = 1'b0, beat_ready = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_stride = '0, cfg_skip = '0;
  logic [CW-1:0] cfg_inner = '0, cfg_groups = '0;
  logic busy, done, beat_valid, mem_write, beat_last;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] buf_addr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  strided_addr_gen #(.AW(AW), .CW(CW)) u_strided_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_scatter(dir_scatter),
    .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_skip(cfg_skip),
    .cfg_inner(cfg_inner), .cfg_groups(cfg_groups),
    .busy(busy), .done(done), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .mem_addr(mem_addr), .buf_addr(buf_addr), .mem_write(mem_write),
    .beat_last(beat_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stall: 0 none, 1 periodic back-pressure
  // poke: 0 none, 1 start mid-run, 2 start on final accept and in done cycle
  task automatic run_xfer(input int base, input int stride, input int skip,
                          input int inner, input int groups, input bit dir,
                          input int stall, input int poke, input string req);
    int total, beats, cyc;
    bit held, seen_done, last_seen;
    logic [AW-1:0] h_mem;
    logic [BW-1:0] h_buf;
    total = inner * groups;
    beats = 0; cyc = 0; held = 0; seen_done = 0; last_seen = 0;
    @(negedge clk);
    cfg_base = AW'(base); cfg_stride = AW'(stride); cfg_skip = AW'(skip);
    cfg_inner = CW'(inner); cfg_groups = CW'(groups); dir_scatter = dir;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_base = 16'h1234; cfg_stride = 16'd9; cfg_inner = 8'd2; cfg_groups = 8'd2;
    dir_scatter = ~dir;
    // R2: first beat or zero-length done in the cycle after start
    if (total == 0) chk(done && !beat_valid, "R8", "done after zero start", done, 1);
    else begin
      chk(beat_valid, "R2", "valid after start", beat_valid, 1);
      chk(mem_addr == AW'(base) && buf_addr == 0, "R2", "first addr", mem_addr, AW'(base));
    end
    while (cyc < 2000) begin
      beat_ready = (stall == 1) ? ((cyc % 3) != 1) : 1'b1;
      start = 1'b0;
      #1;
      if (done) begin
        seen_done = 1;
        if (poke == 2) start = 1'b1;
        break;
      end
      if (held) begin
        chk(beat_valid && mem_addr == h_mem && buf_addr == h_buf, "R6",
            "hold under stall", mem_addr, h_mem);
        held = 0;
      end
      if (beat_valid) begin
        int ii, gg;
        logic [AW-1:0] e;
        ii = beats % inner; gg = beats / inner;
        e = AW'(base + ii * stride + gg * (stride * (inner - 1) + skip));
        if (!beat_ready) begin
          held = 1; h_mem = mem_addr; h_buf = buf_addr;
        end else begin
          chk(mem_addr == e, (ii == 0 && gg > 0) ? "R4" : "R3", "mem_addr", mem_addr, e);
          chk(buf_addr == BW'(beats), "R5", "buf_addr", buf_addr, beats);
          chk(mem_write == dir, "R10", "mem_write", mem_write, dir);
          chk(beat_last == (beats == total - 1), "R7", "beat_last", beat_last, beats == total - 1);
          if (beat_last) last_seen = 1;
          if (poke == 1 && beats == 1) start = 1'b1;
          if (poke == 2 && beats == total - 1) start = 1'b1;
          beats++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    chk(seen_done, req, "done reached", seen_done, 1);
    chk(beats == total, "R7", "beat count", beats, total);
    if (total > 0) chk(last_seen, "R7", "last flag seen", last_seen, 1);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R7", "done width one", done, 0);
    repeat (3) begin
      #1;
      chk(!beat_valid && !busy, (poke != 0) ? "R9" : "R7", "quiet after done",
          beat_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(!busy && !beat_valid && !done, "R1", "reset idle", {busy, beat_valid, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // pitch example: stride 3, 3 items, gap 4 -> pitch 10
    run_xfer(100, 3, 4, 3, 3, 1'b0, 0, 0, "R4");
    run_xfer(20, 1, 1, 4, 2, 1'b1, 1, 0, "R6");
    run_xfer(500, 7, 2, 1, 5, 1'b1, 0, 0, "R4");
    run_xfer(40, 2, 0, 6, 1, 1'b0, 1, 0, "R3");
    run_xfer(30, 5, 5, 0, 4, 1'b0, 0, 0, "R8");
    run_xfer(30, 5, 5, 3, 0, 1'b1, 0, 0, "R8");
    run_xfer(16'hFFF0, 5, 7, 4, 3, 1'b1, 0, 0, "R11");
    run_xfer(64, 4, 3, 3, 2, 1'b0, 1, 1, "R9");
    run_xfer(8, 2, 9, 2, 3, 1'b1, 0, 2, "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule